// File: doc/BRIEF.md
# Rail Protection Response Controller

This block sits beside one regulated rail and converts raw comparator flags (undervoltage, overvoltage, overcurrent, overtemperature and a hard-short flag) into a deterministic protection response. Each comparator is qualified by a consecutive-cycle deglitch filter, and selected comparators are masked while the rail is ramping. Once a fault qualifies, the rail is switched off and the controller either cycles through timed retries or locks the rail off, as a per-fault-type configuration bit selects.

Retries that keep failing escalate to lock-off after a parameterised number of attempts. An overtemperature retry also waits for a lower release level. Lock-off is left only through a host clear strobe or a power-cycle indication. A separate output tells the sequencer that this rail is in a fault action, so the sequencer can take the sibling rails down. A current-limit request follows the overcurrent comparator while the rail is on, which gives foldback before the fault qualifies.

Top module: `rail_prot`

## Requirements
- R1: An asynchronous reset (rst_ni low) puts the controller in Ramp with the rail enabled, cause 0, retry count 0 and fault_act_o low. state_o encodes Normal=0, Ramp=1, Warning=2, Fault=3, Hiccup=4, Latch=5, Cooldown=6.
- R2: While the state is Ramp, the comparators whose bit is set in BLANK_MASK (default undervoltage and overcurrent) are ignored however long they stay high. Ramp moves to Normal on the first edge that samples ramp_i low.
- R3: A comparator qualifies after it is sampled high on DGL_CYC consecutive edges while the rail is on and it is not blanked. The state becomes Fault on the next edge. A low sample restarts the count.
- R4: near_lim_i moves Normal to Warning and Warning back to Normal, one edge each, with the rail kept on.
- R5: Fault lasts one cycle with the rail off and fault_act_o high. The cause is recorded on entry (1 UV, 2 OV, 3 OC, 4 OT, 5 short; priority short > OV > OC > UV > OT). Fault then goes to Latch if the cause's act_cfg_i bit is 1 (bit 0 UV, 1 OV, 2 OC and short, 3 OT), and to Hiccup otherwise.
- R6: Hiccup lasts one cycle and increments the retry count. Cooldown then keeps the rail off for COOL_CYC+1 cycles before it re-enters Ramp. clr_i has no effect during Cooldown.
- R7: After an overtemperature fault, Cooldown also holds until ot_rel_i is high.
- R8: A fault that occurs when the retry count already equals MAX_RETRY goes to Latch instead of Hiccup.
- R9: Latch holds the rail off until clr_i or pcyc_i. Either one moves the state to Ramp and clears the cause and the retry count.
- R10: pcyc_i in any state moves the state to Ramp on the next edge.
- R11: short_i while the rail is on skips deglitch and blanking and gives Fault on the next edge.
- R12: The retry count clears on the (COOL_CYC+1)th consecutive edge in Normal.
- R13: limit_o equals oc_i while the rail is on. fault_act_o is high in Fault, Hiccup, Cooldown and Latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uv_i | input | 1 | Raw undervoltage comparator |
| ov_i | input | 1 | Raw overvoltage comparator |
| oc_i | input | 1 | Raw overcurrent comparator |
| ot_i | input | 1 | Raw overtemperature comparator |
| short_i | input | 1 | Hard overcurrent / rapid undervoltage flag |
| near_lim_i | input | 1 | Near-limit warning flag |
| ramp_i | input | 1 | Rail ramp in progress |
| ot_rel_i | input | 1 | Temperature below release level |
| clr_i | input | 1 | Host clear strobe |
| pcyc_i | input | 1 | Power-cycle indication |
| act_cfg_i | input | 4 | Per-type action select, 1 = latch-off |
| rail_en_o | output | 1 | Rail enable |
| limit_o | output | 1 | Foldback current-limit request |
| fault_act_o | output | 1 | Fault action in progress, to sequencer |
| state_o | output | 3 | State encoding |
| cause_o | output | 3 | Recorded fault cause |
| retry_cnt_o | output | RETRY_W | Hiccup retry count |

## Verification
A wrong internal state shows on rail_en_o and fault_act_o at the edge it is entered, because both outputs decode the state register directly. A deglitch counter that is off by one moves the Fault entry by one edge, and the vectors that sample exactly one edge before and at qualification catch it. A wrong cooldown count or retry-clear timer shows as an early or late Ramp or retry reset at the boundary edge, and a wrong retry count changes the edge on which a persistent short reaches Latch.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_RAMP   = 3'd1,
    ST_WARN   = 3'd2,
    ST_FAULT  = 3'd3,
    ST_HICCUP = 3'd4,
    ST_LATCH  = 3'd5,
    ST_COOL   = 3'd6
  } prot_state_e;

  typedef enum logic [2:0] {
    CS_NONE  = 3'd0,
    CS_UV    = 3'd1,
    CS_OV    = 3'd2,
    CS_OC    = 3'd3,
    CS_OT    = 3'd4,
    CS_SHORT = 3'd5
  } prot_cause_e;

  localparam int NUM_CMP = 4;
  localparam int IDX_UV  = 0;
  localparam int IDX_OV  = 1;
  localparam int IDX_OC  = 2;
  localparam int IDX_OT  = 3;
endpackage

// File: rtl/prot_qual.sv
module prot_qual #(
  parameter int DGL_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic flag_i,
  input  logic blank_i,
  output logic qual_o
);
  localparam int CNT_W = $clog2(DGL_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DGL_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (!en_i || !flag_i || blank_i)  cnt_q <= '0;
    else if (cnt_q != CNT_MAX)             cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/prot_timer.sv
module prot_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/rail_prot.sv
module rail_prot
  import prot_pkg::*;
#(
  parameter int                 DGL_CYC    = 8,
  parameter int                 COOL_CYC   = 1000,
  parameter int                 MAX_RETRY  = 7,
  parameter logic [NUM_CMP-1:0] BLANK_MASK = 4'b0101,
  localparam int                RETRY_W    = $clog2(MAX_RETRY + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               uv_i,
  input  logic               ov_i,
  input  logic               oc_i,
  input  logic               ot_i,
  input  logic               short_i,
  input  logic               near_lim_i,
  input  logic               ramp_i,
  input  logic               ot_rel_i,
  input  logic               clr_i,
  input  logic               pcyc_i,
  input  logic [NUM_CMP-1:0] act_cfg_i,
  output logic               rail_en_o,
  output logic               limit_o,
  output logic               fault_act_o,
  output logic [2:0]         state_o,
  output logic [2:0]         cause_o,
  output logic [RETRY_W-1:0] retry_cnt_o
);
  localparam logic [RETRY_W-1:0] RETRY_MAX = RETRY_W'(MAX_RETRY);

  prot_state_e        state_q, state_d;
  prot_cause_e        cause_q, cause_sel;
  logic [RETRY_W-1:0] retry_q;
  logic [NUM_CMP-1:0] raw, qual;
  logic               mon, trip, in_ramp, latch_sel, cool_done, tmr_clr, unlatch;

  assign raw     = {ot_i, oc_i, ov_i, uv_i};
  assign in_ramp = (state_q == ST_RAMP);
  assign mon     = (state_q == ST_RAMP) || (state_q == ST_NORMAL) || (state_q == ST_WARN);

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_qual
    prot_qual #(.DGL_CYC(DGL_CYC)) u_qual (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (mon),
      .flag_i  (raw[i]),
      .blank_i (in_ramp & BLANK_MASK[i]),
      .qual_o  (qual[i])
    );
  end

  // shared by cooldown and the retry-clear window in Normal
  assign tmr_clr = !((state_q == ST_COOL) || (state_q == ST_NORMAL));

  prot_timer #(.LIMIT(COOL_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .done_o (cool_done)
  );

  assign trip = short_i || (|qual);

  always_comb begin
    if (short_i)           cause_sel = CS_SHORT;
    else if (qual[IDX_OV]) cause_sel = CS_OV;
    else if (qual[IDX_OC]) cause_sel = CS_OC;
    else if (qual[IDX_UV]) cause_sel = CS_UV;
    else                   cause_sel = CS_OT;
  end

  always_comb begin
    unique case (cause_q)
      CS_UV:             latch_sel = act_cfg_i[IDX_UV];
      CS_OV:             latch_sel = act_cfg_i[IDX_OV];
      CS_OC, CS_SHORT:   latch_sel = act_cfg_i[IDX_OC];
      CS_OT:             latch_sel = act_cfg_i[IDX_OT];
      default:           latch_sel = 1'b1;
    endcase
  end

  assign unlatch = pcyc_i || ((state_q == ST_LATCH) && clr_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RAMP:   if (trip) state_d = ST_FAULT;
                 else if (!ramp_i) state_d = ST_NORMAL;
      ST_NORMAL: if (trip) state_d = ST_FAULT;
                 else if (near_lim_i) state_d = ST_WARN;
      ST_WARN:   if (trip) state_d = ST_FAULT;
                 else if (!near_lim_i) state_d = ST_NORMAL;
      ST_FAULT:  state_d = (latch_sel || retry_q == RETRY_MAX) ? ST_LATCH : ST_HICCUP;
      ST_HICCUP: state_d = ST_COOL;
      ST_COOL:   if (cool_done && (cause_q != CS_OT || ot_rel_i)) state_d = ST_RAMP;
      ST_LATCH:  if (clr_i) state_d = ST_RAMP;
      default:   state_d = ST_RAMP;
    endcase
    if (pcyc_i) state_d = ST_RAMP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RAMP;
      cause_q <= CS_NONE;
      retry_q <= '0;
    end else begin
      state_q <= state_d;
      if (unlatch)           cause_q <= CS_NONE;
      else if (mon && trip)  cause_q <= cause_sel;
      if (unlatch)                                   retry_q <= '0;
      else if (state_q == ST_HICCUP)                 retry_q <= retry_q + 1'b1;
      else if (state_q == ST_NORMAL && cool_done)    retry_q <= '0;
    end
  end

  assign rail_en_o   = mon;
  assign fault_act_o = !mon;
  assign limit_o     = oc_i && mon;
  assign state_o     = state_q;
  assign cause_o     = cause_q;
  assign retry_cnt_o = retry_q;
endmodule

// File: rtl/rail_prot_chk.sv
module rail_prot_chk #(
  parameter int MAX_RETRY = 7,
  parameter int RETRY_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               short_i,
  input logic               clr_i,
  input logic               pcyc_i,
  input logic               rail_en_o,
  input logic [2:0]         state_o,
  input logic [RETRY_W-1:0] retry_cnt_o
);
  logic on_st;
  assign on_st = (state_o == 3'd0) || (state_o == 3'd1) || (state_o == 3'd2);

  AST_PCYC_TO_RAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcyc_i |=> state_o == 3'd1);  // R10

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5 && !clr_i && !pcyc_i) |=> state_o == 3'd5);  // R9

  AST_FAULT_ONE_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && !pcyc_i) |=> (state_o == 3'd4 || state_o == 3'd5));  // R5

  AST_COOL_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd6 |=> (state_o == 3'd6 || state_o == 3'd1));  // R6

  AST_SHORT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_st && short_i && !pcyc_i) |=> !rail_en_o);  // R11

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_cnt_o <= RETRY_W'(MAX_RETRY));  // R8
endmodule

bind rail_prot rail_prot_chk #(.MAX_RETRY(MAX_RETRY), .RETRY_W(RETRY_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .short_i     (short_i),
  .clr_i       (clr_i),
  .pcyc_i      (pcyc_i),
  .rail_en_o   (rail_en_o),
  .state_o     (state_o),
  .retry_cnt_o (retry_cnt_o)
);

// File: tb/tb_rail_prot.sv
module tb_rail_prot;
  localparam int DGL = 3;
  localparam int COOL = 8;
  localparam int MAXR = 2;
  localparam int RW = $clog2(MAXR + 1);
  localparam int NV = 43;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic uv = 0, ov = 0, oc = 0, ot = 0, sh = 0, nl = 0, rmp = 1, otr = 0, clr = 0, pc = 0;
  logic [3:0] cfg = 4'b0010;
  logic rail_en, lim, fact;
  logic [2:0] st, cause;
  logic [RW-1:0] retry;
  int checks = 0, errors = 0;
  bit fin = 0;

  always #4 clk = ~clk;

  rail_prot #(.DGL_CYC(DGL), .COOL_CYC(COOL), .MAX_RETRY(MAXR)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .uv_i(uv), .ov_i(ov), .oc_i(oc), .ot_i(ot),
    .short_i(sh), .near_lim_i(nl), .ramp_i(rmp), .ot_rel_i(otr), .clr_i(clr),
    .pcyc_i(pc), .act_cfg_i(cfg), .rail_en_o(rail_en), .limit_o(lim),
    .fault_act_o(fact), .state_o(st), .cause_o(cause), .retry_cnt_o(retry)
  );

  // {req, ot oc ov uv, short ramp warn otrel clr pcyc, cycles, state, en, cause, retry, act}
  localparam logic [31:0] VEC [NV] = '{
    {4'd2,  4'b0001, 6'b010000, 8'd5, 3'd1, 1'b1, 3'd0, 2'd0, 1'b0}, // R2 UV blanked in ramp
    {4'd2,  4'b0000, 6'b000000, 8'd1, 3'd0, 1'b1, 3'd0, 2'd0, 1'b0}, // R2 ramp done
    {4'd4,  4'b0000, 6'b001000, 8'd1, 3'd2, 1'b1, 3'd0, 2'd0, 1'b0}, // R4
    {4'd4,  4'b0000, 6'b000000, 8'd1, 3'd0, 1'b1, 3'd0, 2'd0, 1'b0}, // R4
    {4'd3,  4'b0001, 6'b000000, 8'd2, 3'd0, 1'b1, 3'd0, 2'd0, 1'b0}, // R3 glitch
    {4'd3,  4'b0000, 6'b000000, 8'd1, 3'd0, 1'b1, 3'd0, 2'd0, 1'b0}, // R3 restart
    {4'd3,  4'b0001, 6'b000000, 8'd3, 3'd0, 1'b1, 3'd0, 2'd0, 1'b0}, // R3 just qualified
    {4'd3,  4'b0001, 6'b000000, 8'd1, 3'd3, 1'b0, 3'd1, 2'd0, 1'b1}, // R3 fault
    {4'd5,  4'b0000, 6'b000000, 8'd1, 3'd4, 1'b0, 3'd1, 2'd0, 1'b1}, // R5 hiccup
    {4'd6,  4'b0000, 6'b000000, 8'd1, 3'd6, 1'b0, 3'd1, 2'd1, 1'b1}, // R6 cooldown
    {4'd6,  4'b0000, 6'b000010, 8'd8, 3'd6, 1'b0, 3'd1, 2'd1, 1'b1}, // R6 clr ignored
    {4'd6,  4'b0000, 6'b010000, 8'd1, 3'd1, 1'b1, 3'd1, 2'd1, 1'b0}, // R6 retry ramp
    {4'd12, 4'b0000, 6'b000000, 8'd1, 3'd0, 1'b1, 3'd1, 2'd1, 1'b0}, // R12
    {4'd12, 4'b0000, 6'b000000, 8'd8, 3'd0, 1'b1, 3'd1, 2'd1, 1'b0}, // R12 not yet
    {4'd12, 4'b0000, 6'b000000, 8'd1, 3'd0, 1'b1, 3'd1, 2'd0, 1'b0}, // R12 cleared
    {4'd3,  4'b0010, 6'b000000, 8'd3, 3'd0, 1'b1, 3'd1, 2'd0, 1'b0}, // R3 OV
    {4'd5,  4'b0010, 6'b000000, 8'd1, 3'd3, 1'b0, 3'd2, 2'd0, 1'b1}, // R5 OV cause
    {4'd5,  4'b0000, 6'b000000, 8'd1, 3'd5, 1'b0, 3'd2, 2'd0, 1'b1}, // R5 latch by cfg
    {4'd9,  4'b0000, 6'b000000, 8'd5, 3'd5, 1'b0, 3'd2, 2'd0, 1'b1}, // R9 held
    {4'd9,  4'b0000, 6'b010010, 8'd1, 3'd1, 1'b1, 3'd0, 2'd0, 1'b0}, // R9 clear
    {4'd9,  4'b0000, 6'b000000, 8'd1, 3'd0, 1'b1, 3'd0, 2'd0, 1'b0}, // R9
    {4'd11, 4'b0000, 6'b100000, 8'd1, 3'd3, 1'b0, 3'd5, 2'd0, 1'b1}, // R11 no deglitch
    {4'd11, 4'b0000, 6'b100000, 8'd1, 3'd4, 1'b0, 3'd5, 2'd0, 1'b1}, // R11 hiccup
    {4'd6,  4'b0000, 6'b100000, 8'd1, 3'd6, 1'b0, 3'd5, 2'd1, 1'b1}, // R6
    {4'd6,  4'b0000, 6'b100000, 8'd8, 3'd6, 1'b0, 3'd5, 2'd1, 1'b1}, // R6
    {4'd6,  4'b0000, 6'b110000, 8'd1, 3'd1, 1'b1, 3'd5, 2'd1, 1'b0}, // R6
    {4'd11, 4'b0000, 6'b110000, 8'd1, 3'd3, 1'b0, 3'd5, 2'd1, 1'b1}, // R11 not blanked
    {4'd8,  4'b0000, 6'b110000, 8'd1, 3'd4, 1'b0, 3'd5, 2'd1, 1'b1}, // R8
    {4'd8,  4'b0000, 6'b110000, 8'd1, 3'd6, 1'b0, 3'd5, 2'd2, 1'b1}, // R8
    {4'd8,  4'b0000, 6'b110000, 8'd8, 3'd6, 1'b0, 3'd5, 2'd2, 1'b1}, // R8
    {4'd8,  4'b0000, 6'b110000, 8'd1, 3'd1, 1'b1, 3'd5, 2'd2, 1'b0}, // R8
    {4'd8,  4'b0000, 6'b110000, 8'd1, 3'd3, 1'b0, 3'd5, 2'd2, 1'b1}, // R8
    {4'd8,  4'b0000, 6'b110000, 8'd1, 3'd5, 1'b0, 3'd5, 2'd2, 1'b1}, // R8 escalated
    {4'd10, 4'b0000, 6'b010001, 8'd1, 3'd1, 1'b1, 3'd0, 2'd0, 1'b0}, // R10 power cycle
    {4'd10, 4'b0000, 6'b000000, 8'd1, 3'd0, 1'b1, 3'd0, 2'd0, 1'b0}, // R10
    {4'd7,  4'b1000, 6'b000000, 8'd3, 3'd0, 1'b1, 3'd0, 2'd0, 1'b0}, // R7
    {4'd7,  4'b1000, 6'b000000, 8'd1, 3'd3, 1'b0, 3'd4, 2'd0, 1'b1}, // R7 OT cause
    {4'd7,  4'b0000, 6'b000000, 8'd1, 3'd4, 1'b0, 3'd4, 2'd0, 1'b1}, // R7
    {4'd7,  4'b0000, 6'b000000, 8'd1, 3'd6, 1'b0, 3'd4, 2'd1, 1'b1}, // R7
    {4'd7,  4'b0000, 6'b000000, 8'd8, 3'd6, 1'b0, 3'd4, 2'd1, 1'b1}, // R7
    {4'd7,  4'b0000, 6'b000000, 8'd3, 3'd6, 1'b0, 3'd4, 2'd1, 1'b1}, // R7 held hot
    {4'd7,  4'b0000, 6'b010100, 8'd1, 3'd1, 1'b1, 3'd4, 2'd1, 1'b0}, // R7 released
    {4'd7,  4'b0000, 6'b000000, 8'd1, 3'd0, 1'b1, 3'd4, 2'd1, 1'b0}  // R7
  };

  task automatic check(input int req, input logic [2:0] es, input logic ee,
                       input logic [2:0] ec, input logic [RW-1:0] er, input logic ea);
    checks++;
    if (st !== es || rail_en !== ee || cause !== ec || retry !== er || fact !== ea) begin
      errors++;
      $display("FAIL R%0d actual st=%0d en=%0b cause=%0d retry=%0d act=%0b expected st=%0d en=%0b cause=%0d retry=%0d act=%0b",
               req, st, rail_en, cause, retry, fact, es, ee, ec, er, ea);
    end
  endtask

  task automatic check_bit(input int req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      errors++;
      $display("FAIL R0 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #20;
    check(1, 3'd1, 1'b1, 3'd0, '0, 1'b0);  // R1 reset state
    @(negedge clk) rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ot, oc, ov, uv}            = VEC[i][27:24];
      {sh, rmp, nl, otr, clr, pc} = VEC[i][23:18];
      repeat (int'(VEC[i][17:10])) @(posedge clk);
      #2;
      check(int'(VEC[i][31:28]), VEC[i][9:7], VEC[i][6], VEC[i][5:3], RW'(VEC[i][2:1]), VEC[i][0]);
    end

    // R13 foldback follows oc while rail is on
    @(negedge clk) oc = 1'b1;
    #1 check_bit(13, lim, 1'b1);
    @(posedge clk) #2;
    check(13, 3'd0, 1'b1, 3'd4, RW'(1), 1'b0);
    @(negedge clk) oc = 1'b0;
    #1 check_bit(13, lim, 1'b0);

    // R1 asynchronous reset mid-run
    @(negedge clk) rst_ni = 1'b0; rmp = 1'b1;
    #1 check(1, 3'd1, 1'b1, 3'd0, '0, 1'b0);
    @(negedge clk) rst_ni = 1'b1;

    // R5 OC with latch configured goes straight to Latch
    @(negedge clk) rmp = 1'b0; cfg = 4'b0100;
    @(posedge clk) #2 check(2, 3'd0, 1'b1, 3'd0, '0, 1'b0);  // R2 ramp exit
    @(negedge clk) oc = 1'b1;
    repeat (DGL + 1) @(posedge clk);
    #2 check(5, 3'd3, 1'b0, 3'd3, '0, 1'b1);  // R5 OC cause
    @(posedge clk) #2 check(5, 3'd5, 1'b0, 3'd3, '0, 1'b1);  // R5 latch by cfg
    @(negedge clk) oc = 1'b0; pc = 1'b1; rmp = 1'b1;
    @(posedge clk) #2 check(10, 3'd1, 1'b1, 3'd0, '0, 1'b0);  // R10

    fin = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule